// File: doc/BRIEF.md
# Serial Clock Divisor Search Engine

This block finds a pair of divider settings for a serial port clock. The first is a prescale factor `P` and the second is a rate factor `S`. Together they give a bit rate of `floor(F / (P * (1 + S)))`, where `F` is the input clock frequency. The caller supplies `F` and the wanted rate `T` as 32-bit integers and pulses `start`. The engine then tests candidate pairs one at a time, using a multi-cycle restoring divider. It returns the chosen pair and the rate that pair actually achieves. No floating-point logic is involved.

The search has two passes. The first pass holds `S` fixed in its outer loop and steps `P` in its inner loop. It ends at once if a candidate hits `T` exactly. If a candidate drops below `T`, the first pass hands over to the second pass. The second pass swaps the nesting: `P` is the outer loop and `S` is the inner loop. It stops at the first candidate at or below `T`. A final comparison picks the pass whose result is faster, and ties go to the first pass. A request of zero, or one above half the input clock, is refused with an error flag and no search is run.

Top module: `rate_search`

## Requirements
- R1: For every successful result, `rate` equals `clk_hz / (cps * (1 + scr))` using integer division.
- R2: A reported `cps` lies in 2..253 and a reported `scr` lies in 0..254.
- R3: The first pass starts at `scr` = 0, `cps` = 2. It steps `cps` upward inside each `scr` value. A candidate rate equal to `req_hz` ends the search with that pair.
- R4: In the first pass, a candidate rate below `req_hz` starts the second pass. The second pass starts at `cps` = 2, `scr` = 0, steps `scr` upward inside each `cps` value, and stops at the first candidate rate less than or equal to `req_hz`.
- R5: The first-pass pair is reported when its rate is greater than or equal to the second-pass rate. Otherwise the second-pass pair is reported. The second-pass rate counts as 0 when the second pass never ran.
- R6: If `req_hz` is 0 or exceeds `clk_hz / 2` (rounded down), the block does not search. In that case `done` and `err` are high in the cycle right after `start`, and `cps`, `scr` and `rate` read 0.
- R7: `done` is high for exactly one cycle. `busy` is high from the cycle after an accepted `start` until `done` rises, and `busy` is low while `done` is high.
- R8: A `start` pulse, or a change of `clk_hz` or `req_hz`, while `busy` is high has no effect on the running search or its result, and produces no extra `done`.
- R9: Reset, synchronous and active high, clears `busy`, `done`, `err`, `cps`, `scr` and `rate` to 0 and abandons any search in progress.
- R10: A request equal to `clk_hz / 2` (rounded down) is accepted, and returns `cps` = 2, `scr` = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a search with the present inputs (ignored while busy) |
| clk_hz | input | 32 | Input clock frequency |
| req_hz | input | 32 | Requested bit rate |
| busy | output | 1 | Search in progress |
| done | output | 1 | One-cycle result strobe |
| err | output | 1 | Request refused, valid with done |
| cps | output | 8 | Chosen prescale factor |
| scr | output | 8 | Chosen rate factor |
| rate | output | 32 | Rate achieved by the chosen pair |

## Verification
The assertions check several properties on every cycle:
- Each divider quotient is a true floor division.
- `done` never lasts more than one cycle and never overlaps `busy`.
- Reported factors stay inside their legal ranges.
- Refusals report zeros, and they only happen for an illegal request.

Some behaviour only the bench scenarios can show:
- The nesting order of each pass.
- The handover between passes, and the tie rule in the final choice, including the case where the second pass wins with a large rate factor.
- That a mid-search `start` or a mid-search reset leaves no trace.

// File: rtl/rate_search_pkg.sv
package rate_search_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RUN  = 2'd1,
    ST_ARB  = 2'd2
  } srch_state_e;
endpackage

// File: rtl/seq_divider.sv
module seq_divider #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         go,
  input  logic [W-1:0] num,
  input  logic [W-1:0] den,
  output logic [W-1:0] quo,
  output logic         done
);
  localparam int CNT_W = $clog2(W + 1);

  logic [W-1:0]     rem_q, quo_q, num_q, den_q;
  logic [CNT_W-1:0] cnt_q;
  logic             done_q;
  logic [W:0]       shifted, diff;

  // One restoring step per cycle: bring in the next dividend bit and try a subtract.
  assign shifted = {rem_q, quo_q[W-1]};
  assign diff    = shifted - {1'b0, den_q};

  always_ff @(posedge clk) begin
    if (rst) begin
      rem_q  <= '0;
      quo_q  <= '0;
      num_q  <= '0;
      den_q  <= '0;
      cnt_q  <= '0;
      done_q <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (go) begin
        quo_q <= num;
        num_q <= num;
        den_q <= den;
        rem_q <= '0;
        cnt_q <= CNT_W'(W);
      end else if (cnt_q != '0) begin
        cnt_q <= cnt_q - 1'b1;
        if (!diff[W]) begin
          rem_q <= diff[W-1:0];
          quo_q <= {quo_q[W-2:0], 1'b1};
        end else begin
          rem_q <= shifted[W-1:0];
          quo_q <= {quo_q[W-2:0], 1'b0};
        end
        if (cnt_q == CNT_W'(1)) done_q <= 1'b1;
      end
    end
  end

  assign quo  = quo_q;
  assign done = done_q;

  logic [2*W-1:0] prod;
  assign prod = {{W{1'b0}}, quo_q} * {{W{1'b0}}, den_q};

  AST_DIV_FLOOR: assert property (@(posedge clk) disable iff (rst)
    done_q |-> (prod <= {{W{1'b0}}, num_q}) &&
               ({{W{1'b0}}, num_q} - prod < {{W{1'b0}}, den_q})); // R1
endmodule

// File: rtl/rate_pick.sv
module rate_pick #(
  parameter int W  = 32,
  parameter int CW = 8
) (
  input  logic [W-1:0]  rate_a,
  input  logic [CW-1:0] cps_a,
  input  logic [CW-1:0] scr_a,
  input  logic [W-1:0]  rate_b,
  input  logic [CW-1:0] cps_b,
  input  logic [CW-1:0] scr_b,
  output logic [W-1:0]  rate_o,
  output logic [CW-1:0] cps_o,
  output logic [CW-1:0] scr_o
);
  logic take_b;
  // Ties keep the first-pass pair.
  assign take_b = rate_b > rate_a;

  always_comb begin
    if (take_b) begin
      rate_o = rate_b;
      cps_o  = cps_b;
      scr_o  = scr_b;
    end else begin
      rate_o = rate_a;
      cps_o  = cps_a;
      scr_o  = scr_a;
    end
  end

  always_comb begin
    assert (rate_o >= rate_a && rate_o >= rate_b); // R5
  end
endmodule

// File: rtl/rate_search.sv
module rate_search
  import rate_search_pkg::*;
#(
  parameter int W       = 32,
  parameter int CW      = 8,
  parameter int CPS_MIN = 2,
  parameter int CPS_LIM = 254,
  parameter int SCR_LIM = 255
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start,
  input  logic [W-1:0]  clk_hz,
  input  logic [W-1:0]  req_hz,
  output logic          busy,
  output logic          done,
  output logic          err,
  output logic [CW-1:0] cps,
  output logic [CW-1:0] scr,
  output logic [W-1:0]  rate
);
  localparam logic [CW-1:0] CPS_FIRST = CW'(CPS_MIN);
  localparam logic [CW-1:0] CPS_LAST  = CW'(CPS_LIM - 1);
  localparam logic [CW-1:0] SCR_LAST  = CW'(SCR_LIM - 1);

  srch_state_e   state_q;
  logic          pass2_q, div_go_q;
  logic [W-1:0]  clk_q, req_q;
  logic [CW-1:0] cps_q, scr_q;
  logic [W-1:0]  f1_q, f2_q;
  logic [CW-1:0] c1_q, s1_q, c2_q, s2_q;
  logic          busy_q, done_q, err_q;
  logic [CW-1:0] cps_oq, scr_oq;
  logic [W-1:0]  rate_oq;

  logic [W-1:0]  den, quo;
  logic          div_done;
  logic [W-1:0]  pick_rate;
  logic [CW-1:0] pick_cps, pick_scr;
  logic          bad_req;

  assign den     = W'(cps_q) * (W'(scr_q) + W'(1));
  assign bad_req = (req_hz == '0) || (req_hz > (clk_hz >> 1));

  seq_divider #(.W(W)) u_div (
    .clk(clk), .rst(rst), .go(div_go_q), .num(clk_q), .den(den),
    .quo(quo), .done(div_done)
  );

  rate_pick #(.W(W), .CW(CW)) u_pick (
    .rate_a(f1_q), .cps_a(c1_q), .scr_a(s1_q),
    .rate_b(f2_q), .cps_b(c2_q), .scr_b(s2_q),
    .rate_o(pick_rate), .cps_o(pick_cps), .scr_o(pick_scr)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q  <= ST_IDLE;
      pass2_q  <= 1'b0;
      div_go_q <= 1'b0;
      clk_q    <= '0;
      req_q    <= '0;
      cps_q    <= CPS_FIRST;
      scr_q    <= '0;
      f1_q     <= '0;
      f2_q     <= '0;
      c1_q     <= '0;
      s1_q     <= '0;
      c2_q     <= '0;
      s2_q     <= '0;
      busy_q   <= 1'b0;
      done_q   <= 1'b0;
      err_q    <= 1'b0;
      cps_oq   <= '0;
      scr_oq   <= '0;
      rate_oq  <= '0;
    end else begin
      done_q   <= 1'b0;
      div_go_q <= 1'b0;
      case (state_q)
        ST_IDLE: if (start) begin
          clk_q <= clk_hz;
          req_q <= req_hz;
          if (bad_req) begin
            done_q  <= 1'b1;
            err_q   <= 1'b1;
            cps_oq  <= '0;
            scr_oq  <= '0;
            rate_oq <= '0;
          end else begin
            busy_q   <= 1'b1;
            err_q    <= 1'b0;
            pass2_q  <= 1'b0;
            cps_q    <= CPS_FIRST;
            scr_q    <= '0;
            f2_q     <= '0;
            c2_q     <= '0;
            s2_q     <= '0;
            div_go_q <= 1'b1;
            state_q  <= ST_RUN;
          end
        end
        ST_RUN: if (div_done) begin
          if (!pass2_q) begin
            f1_q <= quo;
            c1_q <= cps_q;
            s1_q <= scr_q;
            if (quo == req_q) begin
              state_q <= ST_ARB;
            end else if (quo < req_q ||
                         (cps_q == CPS_LAST && scr_q == SCR_LAST)) begin
              pass2_q  <= 1'b1;
              cps_q    <= CPS_FIRST;
              scr_q    <= '0;
              div_go_q <= 1'b1;
            end else begin
              div_go_q <= 1'b1;
              if (cps_q == CPS_LAST) begin
                cps_q <= CPS_FIRST;
                scr_q <= scr_q + 1'b1;
              end else begin
                cps_q <= cps_q + 1'b1;
              end
            end
          end else begin
            f2_q <= quo;
            c2_q <= cps_q;
            s2_q <= scr_q;
            if (quo <= req_q || (cps_q == CPS_LAST && scr_q == SCR_LAST)) begin
              state_q <= ST_ARB;
            end else begin
              div_go_q <= 1'b1;
              if (scr_q == SCR_LAST) begin
                scr_q <= '0;
                cps_q <= cps_q + 1'b1;
              end else begin
                scr_q <= scr_q + 1'b1;
              end
            end
          end
        end
        ST_ARB: begin
          cps_oq  <= pick_cps;
          scr_oq  <= pick_scr;
          rate_oq <= pick_rate;
          done_q  <= 1'b1;
          busy_q  <= 1'b0;
          state_q <= ST_IDLE;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign busy = busy_q;
  assign done = done_q;
  assign err  = err_q;
  assign cps  = cps_oq;
  assign scr  = scr_oq;
  assign rate = rate_oq;

  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (rst)
    done_q |=> !done_q); // R7
  AST_DONE_NOT_BUSY: assert property (@(posedge clk) disable iff (rst)
    done_q |-> !busy_q); // R7
  AST_FACTOR_RANGE: assert property (@(posedge clk) disable iff (rst)
    (done_q && !err_q) |-> (cps_oq >= CPS_FIRST && cps_oq <= CPS_LAST && scr_oq <= SCR_LAST)); // R2
  AST_ERR_ZEROS: assert property (@(posedge clk) disable iff (rst)
    (done_q && err_q) |-> (cps_oq == '0 && scr_oq == '0 && rate_oq == '0)); // R6
  AST_ERR_CAUSE: assert property (@(posedge clk) disable iff (rst)
    (done_q && err_q) |-> (req_q == '0 || req_q > (clk_q >> 1))); // R6
  AST_PASS_FIXED: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_RUN && !$rose(busy_q) && pass2_q) |=> pass2_q); // R4
endmodule

// File: tb/test_rate_search.sv
`timescale 1ns/1ps
module test_rate_search;
  localparam int NV = 11;
  localparam int WAIT_LIM = 60000;
  localparam logic [31:0] T_CLK  [NV] = '{32'd1000, 32'd1000, 32'd1000, 32'd48000000,
    32'd50000000, 32'd1001, 32'd1000, 32'd127300, 32'd1000, 32'd1001, 32'd1000};
  localparam logic [31:0] T_REQ  [NV] = '{32'd100, 32'd300, 32'd400, 32'd7000000,
    32'd1000000, 32'd500, 32'd500, 32'd250, 32'd0, 32'd501, 32'd1000};
  localparam logic        T_ERR  [NV] = '{1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0,
    1'b1, 1'b1, 1'b1};
  localparam logic [7:0]  T_CPS  [NV] = '{8'd10, 8'd4, 8'd3, 8'd7, 8'd50, 8'd2, 8'd2, 8'd2,
    8'd0, 8'd0, 8'd0};
  localparam logic [7:0]  T_SCR  [NV] = '{8'd0, 8'd0, 8'd0, 8'd0, 8'd0, 8'd0, 8'd0, 8'd253,
    8'd0, 8'd0, 8'd0};
  localparam logic [31:0] T_RATE [NV] = '{32'd100, 32'd250, 32'd333, 32'd6857142,
    32'd1000000, 32'd500, 32'd500, 32'd250, 32'd0, 32'd0, 32'd0};

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        start = 1'b0;
  logic [31:0] clk_hz = '0, req_hz = '0;
  logic        busy, done, err;
  logic [7:0]  cps, scr;
  logic [31:0] rate;
  int checks = 0, fails = 0;

  always #10 clk = ~clk;

  rate_search i_rate_search (
    .clk(clk), .rst(rst), .start(start), .clk_hz(clk_hz), .req_hz(req_hz),
    .busy(busy), .done(done), .err(err), .cps(cps), .scr(scr), .rate(rate)
  );

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Launch a search; returns the number of extra cycles until done.
  task automatic launch(input logic [31:0] f, input logic [31:0] t, output int waited);
    @(negedge clk);
    clk_hz = f;
    req_hz = t;
    start  = 1'b1;
    @(negedge clk);
    start  = 1'b0;
    waited = 0;
    while (!done && waited < WAIT_LIM) begin
      @(negedge clk);
      waited++;
    end
  endtask

  initial begin
    #(20.0 * 190000);
    checks++;
    fails++;
    $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    int w;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R9: reset state
    chk(busy == 0 && done == 0 && err == 0, "R9 flags", {busy, done, err}, 0);
    chk(cps == 0 && scr == 0 && rate == 0, "R9 outputs", rate, 0);

    for (int i = 0; i < NV; i++) begin
      launch(T_CLK[i], T_REQ[i], w);
      chk(done == 1'b1, "R7 done seen", done, 1);
      chk(err == T_ERR[i], "R6 err flag", err, T_ERR[i]);
      if (T_ERR[i]) chk(w == 0, "R6 immediate done", w, 0);
      chk(cps == T_CPS[i], "R3 R4 R5 cps", cps, T_CPS[i]);
      chk(scr == T_SCR[i], "R3 R4 R5 scr", scr, T_SCR[i]);
      chk(rate == T_RATE[i], "R5 rate", rate, T_RATE[i]);
      if (!T_ERR[i]) begin
        chk(rate == T_CLK[i] / ({24'd0, cps} * ({24'd0, scr} + 1)), "R1 rate formula",
            rate, T_CLK[i] / ({24'd0, cps} * ({24'd0, scr} + 1)));
        chk(cps >= 2 && cps <= 253 && scr <= 254, "R2 range", cps, 2);
      end
      chk(busy == 1'b0, "R7 busy low with done", busy, 0);
      @(negedge clk);
      chk(done == 1'b0, "R7 done one cycle", done, 0);
    end

    // R7: busy rises the cycle after start
    @(negedge clk);
    clk_hz = 1000; req_hz = 100; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk(busy == 1'b1, "R7 busy after start", busy, 1);
    // R8: start with new values while busy is ignored
    repeat (3) @(negedge clk);
    clk_hz = 1000; req_hz = 300; start = 1'b1;
    @(negedge clk);
    start = 1'b0; clk_hz = 5; req_hz = 0;
    w = 0;
    while (!done && w < WAIT_LIM) begin
      @(negedge clk);
      w++;
    end
    chk(cps == 8'd10 && scr == 8'd0 && rate == 32'd100 && err == 0, "R8 result kept",
        rate, 100);
    w = 0;
    repeat (60) begin
      @(negedge clk);
      if (done) w++;
    end
    chk(w == 0, "R8 no extra done", w, 0);

    // R9: reset during a search abandons it
    @(negedge clk);
    clk_hz = 127300; req_hz = 250; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    repeat (100) @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    chk(busy == 0 && done == 0 && rate == 0, "R9 mid-search reset", busy, 0);
    w = 0;
    repeat (60) begin
      @(negedge clk);
      if (done || busy) w++;
    end
    chk(w == 0, "R9 stays idle", w, 0);

    // R10: boundary request after reset
    launch(32'd64, 32'd32, w);
    chk(err == 0 && cps == 2 && scr == 0 && rate == 32, "R10 half clock", rate, 32);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule